// File: doc/BRIEF.md
# Transceiver Reconfiguration Read-Modify-Write Sequencer

This block reprograms configuration registers in a group of serial transceiver channels through a memory-mapped master port. It handles one channel at a time. For each channel it first takes the register bus away from the channel's embedded controller by writing a claim code. It then steps through a table of register offsets. At each offset it reads the register, keeps the bits outside a mask, inserts new bits inside the mask, and writes the result back. When the last offset is done it writes a release code so the embedded controller owns the bus again.

Each channel has its own address window, and the channel index forms the upper address bits. When every channel has been handled, the sequencer asks an external transceiver reset controller for a reset. It holds that request until the controller reports ready, then raises a one-cycle completion pulse and returns to idle. The offset table is a set of static input vectors. Each entry holds a register offset, a bit mask and a value.

Top module: `xcvr_rmw_seq`

## Requirements
- R1: After reset the block is idle: `mm_read`, `mm_write`, `rst_req` and `done` are all low.
- R2: A `start` pulse in idle begins with channel 0. Every channel begins with a write of data 0x02 to address `{channel, 0}`, before any other access in that channel.
- R3: For each table entry i the block reads `{channel, tbl_addr[i]}`. It then writes `(rd & ~tbl_mask[i]) | (tbl_val[i] & tbl_mask[i])` to the same address.
- R4: Within a channel the entries are processed in order, i = 0 up to N_OFS-1. The channel then ends with a write of data 0x03 to address `{channel, 0}`.
- R5: Channels are processed in ascending order, 0 up to N_CH-1, and the entry index starts again at 0 for each channel.
- R6: At most one of `mm_read` and `mm_write` is high. While `mm_waitrequest` is high, the active strobe, `mm_address` and `mm_writedata` stay unchanged. A request is accepted in a cycle where its strobe is high and `mm_waitrequest` is low.
- R7: Read data is taken only in a cycle where `mm_readdatavalid` is high, after the read has been accepted. `mm_readdata` in any other cycle has no effect.
- R8: After the release write of the last channel, `rst_req` goes high and stays high until `rst_ready` is seen high. No bus access happens while `rst_req` is high.
- R9: `done` is high for exactly one cycle, in the cycle after the one where `rst_req` and `rst_ready` are both high. The block is then idle again.
- R10: A `start` pulse while a sequence is running has no effect: it causes no extra accesses and no extra `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a reconfiguration pass (taken only when idle) |
| tbl_addr | input | N_OFS*OFS_AW | Register offsets, entry i at bits [i*OFS_AW +: OFS_AW] |
| tbl_mask | input | N_OFS*DW | Bit masks, entry i at bits [i*DW +: DW] |
| tbl_val | input | N_OFS*DW | New bit values, entry i at bits [i*DW +: DW] |
| mm_address | output | CH_W+OFS_AW | Word address: channel index in the upper bits, offset below |
| mm_read | output | 1 | Read strobe |
| mm_write | output | 1 | Write strobe |
| mm_writedata | output | DW | Write data |
| mm_readdata | input | DW | Read data |
| mm_readdatavalid | input | 1 | Read data valid |
| mm_waitrequest | input | 1 | Slave stall; holds the current request |
| rst_req | output | 1 | Request to the transceiver reset controller |
| rst_ready | input | 1 | Reset controller reports completion |
| done | output | 1 | One-cycle end-of-pass pulse |

## Verification
The bus results are not due a fixed number of cycles after `start`. Each access appears once per accepted handshake, and the position of that handshake depends on the slave's stall count and read latency. For that reason the bench logs every accepted access in the order it happens and compares the log with an order built from the requirements, so the timing of stalls cannot shift any result. The timed results are checked to the exact cycle. `rst_req` must stay high for the ready delay plus one cycle. `done` must rise one cycle after ready is seen and be counted exactly once, and the bench confirms idle outputs a few cycles after that.

// File: rtl/xrs_pkg.sv
package xrs_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_INIT, S_INIT_WR, S_RD, S_MOD, S_WR, S_TRANS,
    S_END_INIT, S_END_INIT_WR, S_RESET, S_DONE
  } xrs_state_e;

  localparam int unsigned CLAIM_CODE   = 2;
  localparam int unsigned RELEASE_CODE = 3;

  // Bits under the mask come from the new value, the rest from the read data.
  function automatic logic [31:0] merge_bits(input logic [31:0] rd,
                                             input logic [31:0] mask,
                                             input logic [31:0] val);
    return (rd & ~mask) | (val & mask);
  endfunction

endpackage

// File: rtl/xrs_loop_cnt.sv
module xrs_loop_cnt #(
  parameter int N_CH  = 2,
  parameter int N_OFS = 3,
  localparam int CH_W = (N_CH  > 1) ? $clog2(N_CH)  : 1,
  localparam int OI_W = (N_OFS > 1) ? $clog2(N_OFS) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ch_clr,
  input  logic            ch_inc,
  input  logic            ofs_clr,
  input  logic            ofs_inc,
  output logic [CH_W-1:0] ch,
  output logic [OI_W-1:0] ofs,
  output logic            ch_last,
  output logic            ofs_last
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ch <= '0;
    else if (ch_clr)  ch <= '0;
    else if (ch_inc)  ch <= ch + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ofs <= '0;
    else if (ofs_clr) ofs <= '0;
    else if (ofs_inc) ofs <= ofs + 1'b1;
  end

  assign ch_last  = (ch  == CH_W'(N_CH - 1));
  assign ofs_last = (ofs == OI_W'(N_OFS - 1));

endmodule

// File: rtl/xrs_tbl_sel.sv
module xrs_tbl_sel #(
  parameter int N_OFS  = 3,
  parameter int OFS_AW = 4,
  parameter int DW     = 32,
  localparam int OI_W  = (N_OFS > 1) ? $clog2(N_OFS) : 1
) (
  input  logic [N_OFS*OFS_AW-1:0] tbl_addr,
  input  logic [N_OFS*DW-1:0]     tbl_mask,
  input  logic [N_OFS*DW-1:0]     tbl_val,
  input  logic [OI_W-1:0]         idx,
  output logic [OFS_AW-1:0]       sel_addr,
  output logic [DW-1:0]           sel_mask,
  output logic [DW-1:0]           sel_val
);

  logic [OFS_AW-1:0] addr_a [N_OFS];
  logic [DW-1:0]     mask_a [N_OFS];
  logic [DW-1:0]     val_a  [N_OFS];

  for (genvar i = 0; i < N_OFS; i++) begin : g_unpack
    assign addr_a[i] = tbl_addr[i*OFS_AW +: OFS_AW];
    assign mask_a[i] = tbl_mask[i*DW +: DW];
    assign val_a[i]  = tbl_val[i*DW +: DW];
  end

  assign sel_addr = addr_a[idx];
  assign sel_mask = mask_a[idx];
  assign sel_val  = val_a[idx];

endmodule

// File: rtl/xrs_merge.sv
module xrs_merge #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap_en,
  input  logic [DW-1:0] rdata,
  input  logic          mod_en,
  input  logic [DW-1:0] mask,
  input  logic [DW-1:0] val,
  output logic [DW-1:0] merged
);
  import xrs_pkg::*;

  logic [DW-1:0] rd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q   <= '0;
      merged <= '0;
    end else begin
      if (cap_en) rd_q <= rdata;
      if (mod_en) merged <= DW'(merge_bits(32'(rd_q), 32'(mask), 32'(val)));
    end
  end

endmodule

// File: rtl/xcvr_rmw_seq.sv
module xcvr_rmw_seq #(
  parameter int N_CH   = 2,
  parameter int N_OFS  = 3,
  parameter int OFS_AW = 4,
  parameter int DW     = 32,
  localparam int CH_W  = (N_CH  > 1) ? $clog2(N_CH)  : 1,
  localparam int OI_W  = (N_OFS > 1) ? $clog2(N_OFS) : 1,
  localparam int AW    = CH_W + OFS_AW
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [N_OFS*OFS_AW-1:0] tbl_addr,
  input  logic [N_OFS*DW-1:0]     tbl_mask,
  input  logic [N_OFS*DW-1:0]     tbl_val,
  output logic [AW-1:0]           mm_address,
  output logic                    mm_read,
  output logic                    mm_write,
  output logic [DW-1:0]           mm_writedata,
  input  logic [DW-1:0]           mm_readdata,
  input  logic                    mm_readdatavalid,
  input  logic                    mm_waitrequest,
  output logic                    rst_req,
  input  logic                    rst_ready,
  output logic                    done
);
  import xrs_pkg::*;

  xrs_state_e        st;
  logic              rd_issued;
  logic [CH_W-1:0]   ch_cnt;
  logic [OI_W-1:0]   ofs_cnt;
  logic              ch_last, ofs_last;
  logic              ch_clr, ch_inc, ofs_clr, ofs_inc;
  logic [OFS_AW-1:0] cur_addr;
  logic [DW-1:0]     cur_mask, cur_val, merged;

  // Named events, also used by the checker.
  logic ev_accept, ev_capture, ev_start, ev_owner_phase;
  assign ev_accept      = (mm_read | mm_write) & ~mm_waitrequest;
  assign ev_capture     = (st == S_RD) & rd_issued & mm_readdatavalid;
  assign ev_start       = (st == S_IDLE) & start;
  assign ev_owner_phase = (st == S_INIT_WR) | (st == S_END_INIT_WR);

  xrs_loop_cnt #(.N_CH(N_CH), .N_OFS(N_OFS)) u_cnt (
    .clk(clk), .rst_n(rst_n),
    .ch_clr(ch_clr), .ch_inc(ch_inc), .ofs_clr(ofs_clr), .ofs_inc(ofs_inc),
    .ch(ch_cnt), .ofs(ofs_cnt), .ch_last(ch_last), .ofs_last(ofs_last)
  );

  xrs_tbl_sel #(.N_OFS(N_OFS), .OFS_AW(OFS_AW), .DW(DW)) u_sel (
    .tbl_addr(tbl_addr), .tbl_mask(tbl_mask), .tbl_val(tbl_val),
    .idx(ofs_cnt), .sel_addr(cur_addr), .sel_mask(cur_mask), .sel_val(cur_val)
  );

  xrs_merge #(.DW(DW)) u_merge (
    .clk(clk), .rst_n(rst_n),
    .cap_en(ev_capture), .rdata(mm_readdata),
    .mod_en(st == S_MOD), .mask(cur_mask), .val(cur_val),
    .merged(merged)
  );

  always_comb begin
    ch_clr  = ev_start;
    ofs_clr = ev_start | ((st == S_END_INIT_WR) & ~mm_waitrequest);
    ch_inc  = (st == S_END_INIT_WR) & ~mm_waitrequest & ~ch_last;
    ofs_inc = (st == S_TRANS) & ~ofs_last;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      rd_issued <= 1'b0;
    end else begin
      unique case (st)
        S_IDLE:     if (start) st <= S_INIT;
        S_INIT:     st <= S_INIT_WR;
        S_INIT_WR:  if (!mm_waitrequest) st <= S_RD;
        S_RD: begin
          if (!rd_issued) begin
            if (!mm_waitrequest) rd_issued <= 1'b1;
          end else if (mm_readdatavalid) begin
            rd_issued <= 1'b0;
            st        <= S_MOD;
          end
        end
        S_MOD:      st <= S_WR;
        S_WR:       if (!mm_waitrequest) st <= S_TRANS;
        S_TRANS:    st <= ofs_last ? S_END_INIT : S_RD;
        S_END_INIT: st <= S_END_INIT_WR;
        S_END_INIT_WR:
          if (!mm_waitrequest) st <= ch_last ? S_RESET : S_INIT;
        S_RESET:    if (rst_ready) st <= S_DONE;
        S_DONE:     st <= S_IDLE;
        default:    st <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    mm_read  = (st == S_RD) & ~rd_issued;
    mm_write = ev_owner_phase | (st == S_WR);
    mm_address = ev_owner_phase ? {ch_cnt, {OFS_AW{1'b0}}} : {ch_cnt, cur_addr};
    if (st == S_INIT_WR)          mm_writedata = DW'(CLAIM_CODE);
    else if (st == S_END_INIT_WR) mm_writedata = DW'(RELEASE_CODE);
    else                          mm_writedata = merged;
  end

  assign rst_req = (st == S_RESET);
  assign done    = (st == S_DONE);

endmodule

// File: rtl/xrs_chk.sv
module xrs_chk #(
  parameter int N_CH  = 2,
  parameter int N_OFS = 3,
  parameter int CH_W  = 1,
  parameter int OI_W  = 2,
  parameter int AW    = 5,
  parameter int DW    = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic [AW-1:0]   mm_address,
  input logic            mm_read,
  input logic            mm_write,
  input logic [DW-1:0]   mm_writedata,
  input logic            mm_waitrequest,
  input logic            rst_req,
  input logic            rst_ready,
  input logic            done,
  input logic [CH_W-1:0] ch_cnt,
  input logic [OI_W-1:0] ofs_cnt
);

  a_r6_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(mm_read && mm_write));

  a_r6_hold_write: assert property (@(posedge clk) disable iff (!rst_n)
    (mm_write && mm_waitrequest) |=>
      (mm_write && $stable(mm_address) && $stable(mm_writedata)));

  a_r6_hold_read: assert property (@(posedge clk) disable iff (!rst_n)
    (mm_read && mm_waitrequest) |=> (mm_read && $stable(mm_address)));

  a_r5_ch_range: assert property (@(posedge clk) disable iff (!rst_n)
    ch_cnt <= CH_W'(N_CH - 1));

  a_r4_ofs_range: assert property (@(posedge clk) disable iff (!rst_n)
    ofs_cnt <= OI_W'(N_OFS - 1));

  a_r8_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_req && !rst_ready) |=> rst_req);

  a_r8_bus_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> (!mm_read && !mm_write));

  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r9_done_after_ready: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(rst_req && rst_ready));

endmodule

bind xcvr_rmw_seq xrs_chk #(
  .N_CH(N_CH), .N_OFS(N_OFS), .CH_W(CH_W), .OI_W(OI_W), .AW(AW), .DW(DW)
) u_xrs_chk (
  .clk(clk), .rst_n(rst_n), .mm_address(mm_address), .mm_read(mm_read),
  .mm_write(mm_write), .mm_writedata(mm_writedata),
  .mm_waitrequest(mm_waitrequest), .rst_req(rst_req), .rst_ready(rst_ready),
  .done(done), .ch_cnt(ch_cnt), .ofs_cnt(ofs_cnt)
);

// File: tb/test_xcvr_rmw_seq.sv
`timescale 1ns/1ps
module test_xcvr_rmw_seq;
  localparam int N_CH = 2, N_OFS = 3, OFS_AW = 4, DW = 32;
  localparam int AW = 1 + OFS_AW;
  localparam int RDY_DLY = 4;
  localparam int N_LOG = N_CH * (2 + 2 * N_OFS);

  typedef struct packed {
    logic [31:0] seed;
    logic [31:0] m0, m1, m2;
    logic [31:0] v0, v1, v2;
    logic [3:0]  wt;
    logic [3:0]  lat;
    logic        busy_start;
  } vec_t;

  localparam vec_t VECS [3] = '{
    '{32'h0000_0000, 32'hFFFF_FFFF, 32'h0000_00F0, 32'h0000_0000,
      32'h1234_5678, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 4'd0, 4'd1, 1'b0},
    '{32'hA5A5_A5A5, 32'h8000_0001, 32'h00FF_0000, 32'h0F0F_0F0F,
      32'h0000_0000, 32'h0012_0000, 32'hFFFF_FFFF, 4'd2, 4'd3, 1'b0},
    '{32'h5A5A_0F0F, 32'hFFFF_0000, 32'h0000_0001, 32'h0000_0007,
      32'hDEAD_0000, 32'h0000_0000, 32'h0000_0005, 4'd1, 4'd2, 1'b1}
  };
  localparam logic [OFS_AW-1:0] OFS_A [N_OFS] = '{4'd1, 4'd6, 4'd15};

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [N_OFS*OFS_AW-1:0] tbl_addr;
  logic [N_OFS*DW-1:0] tbl_mask, tbl_val;
  logic [AW-1:0] mm_address;
  logic mm_read, mm_write, mm_readdatavalid, mm_waitrequest, rst_req, rst_ready, done;
  logic [DW-1:0] mm_writedata, mm_readdata;

  always #2 clk = ~clk;

  xcvr_rmw_seq #(.N_CH(N_CH), .N_OFS(N_OFS), .OFS_AW(OFS_AW), .DW(DW)) i_xcvr_rmw_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .tbl_addr(tbl_addr),
    .tbl_mask(tbl_mask), .tbl_val(tbl_val), .mm_address(mm_address),
    .mm_read(mm_read), .mm_write(mm_write), .mm_writedata(mm_writedata),
    .mm_readdata(mm_readdata), .mm_readdatavalid(mm_readdatavalid),
    .mm_waitrequest(mm_waitrequest), .rst_req(rst_req), .rst_ready(rst_ready),
    .done(done)
  );

  int errors = 0, checks = 0;

  // Slave model and monitors.
  logic [DW-1:0] mem [2**AW];
  logic [3:0] cur_wait = 0, cur_lat = 1, wcnt = 0, rv_cnt = 0;
  logic [DW-1:0] rv_data = '0;
  int rdy_cnt = 0;
  logic log_wr [64];
  logic [AW-1:0] log_ad [64];
  logic [DW-1:0] log_da [64];
  int log_n = 0, done_cnt = 0, req_cycles = 0, log_at_req = -1;

  assign mm_waitrequest   = (mm_read | mm_write) && (wcnt < cur_wait);
  assign mm_readdatavalid = (rv_cnt == 4'd1);
  assign mm_readdata      = mm_readdatavalid ? rv_data : 32'hBAD0_BAD0;
  assign rst_ready        = rst_req && (rdy_cnt == RDY_DLY);

  always @(posedge clk) begin
    if (rv_cnt != 0) rv_cnt <= rv_cnt - 4'd1;
    if ((mm_read | mm_write) && mm_waitrequest) wcnt <= wcnt + 4'd1;
    if ((mm_read | mm_write) && !mm_waitrequest) begin
      wcnt <= 0;
      if (log_n < 64) begin
        log_wr[log_n] <= mm_write;
        log_ad[log_n] <= mm_address;
        log_da[log_n] <= mm_write ? mm_writedata : '0;
      end
      log_n <= log_n + 1;
      if (mm_write) mem[mm_address] <= mm_writedata;
      else begin
        rv_cnt  <= cur_lat;
        rv_data <= mem[mm_address];
      end
    end
    rdy_cnt <= rst_req ? rdy_cnt + 1 : 0;
    if (rst_req) req_cycles <= req_cycles + 1;
    if (rst_req && log_at_req < 0) log_at_req <= log_n;
    if (done) done_cnt <= done_cnt + 1;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] init_of(input logic [31:0] seed, input int a);
    return seed ^ (32'(a) * 32'h0101_0101);
  endfunction

  task automatic run_vec(input vec_t v);
    logic [DW-1:0] m [N_OFS];
    logic [DW-1:0] vv [N_OFS];
    logic e_wr [N_LOG];
    logic [AW-1:0] e_ad [N_LOG];
    logic [DW-1:0] e_da [N_LOG];
    int k = 0;
    m = '{v.m0, v.m1, v.m2};
    vv = '{v.v0, v.v1, v.v2};
    for (int a = 0; a < 2**AW; a++) mem[a] = init_of(v.seed, a);
    tbl_mask = {v.m2, v.m1, v.m0};
    tbl_val  = {v.v2, v.v1, v.v0};
    cur_wait = v.wt;
    cur_lat  = v.lat;
    log_n = 0; done_cnt = 0; req_cycles = 0; log_at_req = -1;
    // Expected access order from R2..R5.
    for (int c = 0; c < N_CH; c++) begin
      e_wr[k] = 1; e_ad[k] = AW'(c << OFS_AW); e_da[k] = 32'h2; k++;
      for (int i = 0; i < N_OFS; i++) begin
        logic [AW-1:0] a = AW'((c << OFS_AW) | int'(OFS_A[i]));
        e_wr[k] = 0; e_ad[k] = a; e_da[k] = '0; k++;
        e_wr[k] = 1; e_ad[k] = a;
        e_da[k] = (init_of(v.seed, int'(a)) & ~m[i]) | (vv[i] & m[i]); k++;
      end
      e_wr[k] = 1; e_ad[k] = AW'(c << OFS_AW); e_da[k] = 32'h3; k++;
    end
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    if (v.busy_start) begin
      repeat (30) @(negedge clk);
      start = 1'b1;             // R10: ignored while busy
      @(negedge clk); start = 1'b0;
    end
    for (int t = 0; t < 5000 && done_cnt == 0; t++) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(log_n == N_LOG, "R10 access count", 64'(log_n), 64'(N_LOG));
    for (int j = 0; j < N_LOG && j < log_n; j++)
      chk(log_wr[j] == e_wr[j] && log_ad[j] == e_ad[j] && log_da[j] == e_da[j],
          "R3 R4 R5 access order",
          {31'd0, log_wr[j], log_ad[j][AW-1:0], 27'd0, log_da[j]} >> 0,
          {31'd0, e_wr[j], e_ad[j][AW-1:0], 27'd0, e_da[j]} >> 0);
    for (int c = 0; c < N_CH; c++)
      chk(mem[AW'(c << OFS_AW)] == 32'h3, "R4 release code", 64'(mem[AW'(c << OFS_AW)]), 64'h3);
    chk(log_wr[0] == 1 && log_da[0] == 32'h2, "R2 claim first", 64'(log_da[0]), 64'h2);
    chk(log_at_req == N_LOG, "R8 bus quiet at reset request", 64'(log_at_req), 64'(N_LOG));
    chk(req_cycles == RDY_DLY + 1, "R8 request held until ready", 64'(req_cycles), 64'(RDY_DLY + 1));
    chk(done_cnt == 1, "R9 R10 single done pulse", 64'(done_cnt), 64'd1);
    chk(!mm_read && !mm_write && !rst_req && !done, "R9 idle after done",
        {60'd0, mm_read, mm_write, rst_req, done}, 64'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    tbl_addr = {OFS_A[2], OFS_A[1], OFS_A[0]};
    tbl_mask = '0; tbl_val = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!mm_read && !mm_write && !rst_req && !done, "R1 reset state",
        {60'd0, mm_read, mm_write, rst_req, done}, 64'd0);
    // R1: no activity without start
    repeat (5) @(negedge clk);
    chk(log_n == 0 && done_cnt == 0, "R1 stays idle", 64'(log_n), 64'd0);
    for (int n = 0; n < 3; n++) run_vec(VECS[n]);
    // R7: corrupted read data outside valid cycles already drives 0xBAD0BAD0;
    // a second pass with long latency confirms only valid data is merged.
    begin
      vec_t v7 = '{32'h0F0F_F0F0, 32'h0000_FFFF, 32'h0, 32'hFFFF_FFFF,
                   32'h0000_1111, 32'h0, 32'h0, 4'd3, 4'd5, 1'b0};
      run_vec(v7);  // R7
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule